// File: doc/BRIEF.md
# Half-Precision Operand Alignment Unit

This unit sits in front of the significand adder of a half-precision add/subtract datapath. It accepts two regular operands, meaning normals, subnormals or zeros, never infinities or NaNs. The second operand's sign has already been flipped when the operation is a subtraction. The unit widens each operand into a 15-bit significand and decides which operand has the larger magnitude. It then right-shifts the smaller significand so that both significands refer to one common exponent.

Internally, each operand is classified as normal or subnormal, and a two-bit type code picks the alignment path:

- When both operands are subnormal, the significands are only compared and ordered, and the exponent is zero.
- When at least one operand is normal, the exponents are compared first and the smaller significand is shifted by their difference.

All results are registered once. They appear one clock after the inputs are presented, and are forced to zero while the enable is low.

Top module: `fp_align_unit`

## Requirements
- R1: Each operand is widened to a 15-bit significand laid out as bit 14 = hidden bit (1 when the 5-bit exponent field, bits 14:10 of the operand, is nonzero, else 0), bits 13:4 = the 10 fraction bits (operand bits 9:0), bits 3:0 = zero guard bits. The larger significand output therefore always has bits 3:0 equal to zero.
- R2: When both exponent fields are zero (both subnormal), the exponent output is 0 and the larger significand output equals the larger widened significand unshifted, the smaller one also unshifted.
- R3: When at least one exponent field is nonzero, the exponent output equals the larger of the two exponent fields, and the larger significand output has bit 14 set.
- R4: The larger-A flag is 1 exactly when the magnitude of A exceeds that of B, deciding on the exponent first and on the significand when exponents tie.
- R5: The larger significand output holds the widened significand of the operand with the greater magnitude (B's when the flag is 0).
- R6: The smaller significand output is the other operand's widened significand shifted right by the difference of effective exponents, where a subnormal's effective exponent is 1; shifted-out bits are dropped.
- R7: A shift distance of 15 or more gives a smaller significand output of zero.
- R8: Operands of equal magnitude give a flag of 0, B's significand on the larger output and A's on the smaller output.
- R9: A clock edge with the enable low sets every output to zero.
- R10: The two sign outputs equal bit 15 of A and of B, respectively, from the cycle the operands were accepted.
- R11: All outputs are zero while the synchronous active-low reset is asserted and on the first cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Accept operands this cycle; outputs clear when low |
| op_a | input | 16 | Operand A, half-precision bit pattern |
| op_b | input | 16 | Operand B, sign already adjusted for the operation |
| sign_a | output | 1 | Sign of A |
| sign_b | output | 1 | Sign of B |
| a_larger | output | 1 | A's magnitude is greater than B's |
| exp_out | output | 5 | Common exponent after alignment |
| sig_big | output | 15 | Significand of the larger operand |
| sig_small | output | 15 | Aligned significand of the smaller operand |

## Verification
The operand swap and the collapse of the shift to zero can occur in the same cycle. This happens when B is far larger than A, so B's significand is routed to the larger output while A's significand is pushed entirely past the guard bits. The sweep reaches this case by pairing every exponent with every other exponent, including gaps of 15 to 29. Each result is judged against a model that scales both operands to exact integers, compares those integers and divides the smaller by the larger's weight. This checks the routing and the truncation together, without relying on how the unit splits the work.

// File: rtl/fpa_pkg.sv
// Shared types for the operand alignment unit.
package fpa_pkg;
    // Classification of an operand pair; selects the alignment path.
    typedef enum logic [1:0] {
        TY_BOTH_SUB  = 2'b00,
        TY_BOTH_NORM = 2'b01,
        TY_MIXED     = 2'b10
    } optype_e;
endpackage

// File: rtl/fpa_widen.sv
// Widens one operand: splits sign, derives the effective exponent
// (1 for subnormals) and builds hidden bit + fraction + zero guard bits.
// Assumes a regular operand (exponent field not all ones).
module fpa_widen #(
    parameter int EXP_W   = 5,
    parameter int FRAC_W  = 10,
    parameter int GUARD_W = 4,
    localparam int OP_W   = 1 + EXP_W + FRAC_W,
    localparam int SIG_W  = 1 + FRAC_W + GUARD_W
) (
    input  logic [OP_W-1:0]  op,
    output logic             sign,
    output logic             is_norm,
    output logic [EXP_W-1:0] eff_exp,
    output logic [SIG_W-1:0] sig
);
    logic [EXP_W-1:0] exp_fld;

    // Field split, hidden bit and effective exponent.
    always_comb begin
        sign    = op[OP_W-1];
        exp_fld = op[OP_W-2 -: EXP_W];
        is_norm = |exp_fld;
        eff_exp = is_norm ? exp_fld : EXP_W'(1);
        sig     = {is_norm, op[FRAC_W-1:0], {GUARD_W{1'b0}}};
    end
endmodule

// File: rtl/fpa_order.sv
// Classifies the pair, decides which magnitude is larger, picks the
// common exponent and the shift distance for the smaller significand.
// Equal magnitudes leave B as the larger operand.
module fpa_order
    import fpa_pkg::*;
#(
    parameter int EXP_W = 5,
    parameter int SIG_W = 15
) (
    input  logic             norm_a,
    input  logic             norm_b,
    input  logic [EXP_W-1:0] eff_a,
    input  logic [EXP_W-1:0] eff_b,
    input  logic [SIG_W-1:0] sig_a,
    input  logic [SIG_W-1:0] sig_b,
    output optype_e          ty,
    output logic             a_gt,
    output logic [EXP_W-1:0] exp_sel,
    output logic [SIG_W-1:0] sig_hi,
    output logic [SIG_W-1:0] sig_lo_raw,
    output logic [EXP_W-1:0] shamt
);
    // Pair classification into the two-bit type code.
    always_comb begin
        if (!norm_a && !norm_b)     ty = TY_BOTH_SUB;
        else if (norm_a && norm_b)  ty = TY_BOTH_NORM;
        else                        ty = TY_MIXED;
    end

    // Magnitude comparison: exponent first, significand on a tie.
    always_comb begin
        a_gt = (eff_a > eff_b) || ((eff_a == eff_b) && (sig_a > sig_b));
    end

    // Operand routing, exponent and shift distance per path.
    always_comb begin
        sig_hi     = a_gt ? sig_a : sig_b;
        sig_lo_raw = a_gt ? sig_b : sig_a;
        case (ty)
            TY_BOTH_SUB: begin
                exp_sel = '0;
                shamt   = '0;
            end
            default: begin
                exp_sel = a_gt ? eff_a : eff_b;
                shamt   = a_gt ? (eff_a - eff_b) : (eff_b - eff_a);
            end
        endcase
    end
endmodule

// File: rtl/fpa_rshift.sv
// Logarithmic right shifter; bits leaving the bottom are dropped, so any
// distance of SIG_W or more yields zero.
module fpa_rshift #(
    parameter int SIG_W = 15,
    parameter int SH_W  = 5
) (
    input  logic [SIG_W-1:0] din,
    input  logic [SH_W-1:0]  shamt,
    output logic [SIG_W-1:0] dout
);
    logic [SIG_W-1:0] stg [SH_W+1];

    assign stg[0] = din;

    // One stage per shift-amount bit, each moving by a power of two.
    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        assign stg[k+1] = shamt[k] ? (stg[k] >> (2**k)) : stg[k];
    end

    assign dout = stg[SH_W];
endmodule

// File: rtl/fp_align_unit.sv
// Operand alignment unit: widens both operands, orders them by magnitude
// and aligns the smaller significand to the larger exponent. One register
// stage; outputs clear while disabled. Assumes regular operands and B's
// sign already adjusted for the requested operation.
module fp_align_unit
    import fpa_pkg::*;
#(
    parameter int EXP_W   = 5,
    parameter int FRAC_W  = 10,
    parameter int GUARD_W = 4,
    localparam int OP_W   = 1 + EXP_W + FRAC_W,
    localparam int SIG_W  = 1 + FRAC_W + GUARD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [OP_W-1:0]  op_a,
    input  logic [OP_W-1:0]  op_b,
    output logic             sign_a,
    output logic             sign_b,
    output logic             a_larger,
    output logic [EXP_W-1:0] exp_out,
    output logic [SIG_W-1:0] sig_big,
    output logic [SIG_W-1:0] sig_small
);
    logic [OP_W-1:0]  ops    [2];
    logic             sgn    [2];
    logic             nrm    [2];
    logic [EXP_W-1:0] eff    [2];
    logic [SIG_W-1:0] sig    [2];

    optype_e          ty;
    logic             a_gt;
    logic [EXP_W-1:0] exp_sel;
    logic [SIG_W-1:0] sig_hi;
    logic [SIG_W-1:0] sig_lo_raw;
    logic [SIG_W-1:0] sig_lo;
    logic [EXP_W-1:0] shamt;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    // One widening slice per operand.
    for (genvar i = 0; i < 2; i++) begin : g_widen
        fpa_widen #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .GUARD_W(GUARD_W)) u_widen (
            .op      (ops[i]),
            .sign    (sgn[i]),
            .is_norm (nrm[i]),
            .eff_exp (eff[i]),
            .sig     (sig[i])
        );
    end

    fpa_order #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_order (
        .norm_a     (nrm[0]),
        .norm_b     (nrm[1]),
        .eff_a      (eff[0]),
        .eff_b      (eff[1]),
        .sig_a      (sig[0]),
        .sig_b      (sig[1]),
        .ty         (ty),
        .a_gt       (a_gt),
        .exp_sel    (exp_sel),
        .sig_hi     (sig_hi),
        .sig_lo_raw (sig_lo_raw),
        .shamt      (shamt)
    );

    fpa_rshift #(.SIG_W(SIG_W), .SH_W(EXP_W)) u_rshift (
        .din   (sig_lo_raw),
        .shamt (shamt),
        .dout  (sig_lo)
    );

    // Output register: clear on reset or when disabled, else capture.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            sign_a    <= 1'b0;
            sign_b    <= 1'b0;
            a_larger  <= 1'b0;
            exp_out   <= '0;
            sig_big   <= '0;
            sig_small <= '0;
        end else begin
            sign_a    <= sgn[0];
            sign_b    <= sgn[1];
            a_larger  <= a_gt;
            exp_out   <= exp_sel;
            sig_big   <= sig_hi;
            sig_small <= sig_lo;
        end
    end

    AST_GUARD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sig_big[GUARD_W-1:0] == '0); // R1
    AST_SUBN_EXP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op_a[OP_W-2 -: EXP_W] == '0 && op_b[OP_W-2 -: EXP_W] == '0) |=> (exp_out == '0)); // R2
    AST_NORM_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_out != '0) |-> sig_big[SIG_W-1]); // R3
    AST_SMALL_NOT_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
        sig_small <= sig_big); // R5
    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (sig_big == '0 && sig_small == '0 && exp_out == '0 && !a_larger && !sign_a && !sign_b)); // R9
    AST_SIGN_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (sign_a == $past(op_a[OP_W-1]) && sign_b == $past(op_b[OP_W-1]))); // R10
endmodule

// File: tb/test_fp_align_unit.sv
// Near-exhaustive sweep: every exponent pair with several fraction
// patterns; expected values come from exact integer magnitudes.
module test_fp_align_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic        sign_a, sign_b, a_larger;
    logic [4:0]  exp_out;
    logic [14:0] sig_big, sig_small;

    int n_vec = 0;
    int n_bad = 0;

    fp_align_unit i_fp_align_unit (
        .clk(clk), .rst_n(rst_n), .en(en), .op_a(op_a), .op_b(op_b),
        .sign_a(sign_a), .sign_b(sign_b), .a_larger(a_larger),
        .exp_out(exp_out), .sig_big(sig_big), .sig_small(sig_small)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (a=%h b=%h)", req, act, exp_v, op_a, op_b);
        end
    endtask

    task automatic chk_zero(input string req);
        n_vec++;
        chk(req, {sign_a, sign_b, a_larger}, 32'd0);
        chk(req, 32'(exp_out), 32'd0);
        chk(req, 32'(sig_big), 32'd0);
        chk(req, 32'(sig_small), 32'd0);
    endtask

    // Apply one enabled vector and compare one cycle later.
    task automatic run_vec(input int sa, input int ea, input int fa,
                           input int sb, input int eb, input int fb);
        logic [63:0] ma, mb, big_m, small_m;
        int eff_a, eff_b, e_big, e_exp, sh;
        logic gt;
        @(negedge clk);
        en   = 1'b1;
        op_a = {sa[0], ea[4:0], fa[9:0]};
        op_b = {sb[0], eb[4:0], fb[9:0]};
        eff_a = (ea == 0) ? 1 : ea;
        eff_b = (eb == 0) ? 1 : eb;
        ma = ({63'd0, ea != 0} << 14 | 64'(fa) << 4) << (eff_a - 1);
        mb = ({63'd0, eb != 0} << 14 | 64'(fb) << 4) << (eff_b - 1);
        gt = ma > mb;
        e_big   = gt ? eff_a : eff_b;
        big_m   = gt ? ma : mb;
        small_m = gt ? mb : ma;
        e_exp   = (ea == 0 && eb == 0) ? 0 : e_big;
        sh      = gt ? eff_a - eff_b : eff_b - eff_a;
        @(negedge clk);
        n_vec++;
        chk("R10 sign_a", 32'(sign_a), 32'(sa & 1));
        chk("R10 sign_b", 32'(sign_b), 32'(sb & 1));
        chk(ma == mb ? "R8 flag" : "R4 flag", 32'(a_larger), 32'(gt));
        chk(e_exp == 0 ? "R2 exp" : "R3 exp", 32'(exp_out), 32'(e_exp));
        chk(e_exp == 0 ? "R2 big" : "R5 big", 32'(sig_big), 32'(big_m >> (e_big - 1)));
        chk("R1 guard", 32'(sig_big[3:0]), 32'd0);
        chk(sh >= 15 ? "R7 small" : "R6 small", 32'(sig_small),
            32'((small_m >> (e_big - 1)) & 64'h7FFF));
    endtask

    initial begin
        int fr [4];
        fr[0] = 0; fr[1] = 1; fr[2] = 'h2AA; fr[3] = 'h3FF;
        repeat (3) @(negedge clk);
        chk_zero("R11 reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_zero("R11 after reset");
        for (int ea = 0; ea < 31; ea++)
            for (int eb = 0; eb < 31; eb++)
                for (int ia = 0; ia < 4; ia++)
                    for (int ib = 0; ib < 4; ib++)
                        run_vec((ea + ia) & 1, ea, fr[ia], (eb + ib + 1) & 1, eb, fr[ib]);
        // Equal magnitudes in each path (R8).
        run_vec(0, 0, 'h155, 1, 0, 'h155);
        run_vec(1, 17, 'h3C0, 0, 17, 'h3C0);
        // Disable after a nonzero result clears everything (R9).
        run_vec(1, 20, 'h123, 1, 3, 'h321);
        @(negedge clk);
        en = 1'b0;
        op_a = 16'hFBFF;
        op_b = 16'hABCD;
        @(negedge clk);
        chk_zero("R9 disabled");
        // Reset in mid-stream clears outputs (R11).
        run_vec(0, 9, 'h0F0, 1, 12, 'h00F);
        @(negedge clk);
        rst_n = 1'b0;
        en = 1'b1;
        @(negedge clk);
        chk_zero("R11 mid reset");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule